// File: doc/BRIEF.md
# UART Receive Buffer with Character Timeout

This block sits between a serial deserializer and the register interface of a 16550-style UART. It takes each received character, and each received break, as a one-cycle strobe. It stores them either in a 16-entry first-in first-out buffer or, when buffering is switched off, in a single holding register. It keeps the data-ready, overrun and break line-status flags. It also reports the fill level, and whether that level has reached a programmable trigger.

A character-time tick from the baud logic drives a four-character inactivity timer. When the timer runs out while bytes are waiting, the block raises a timeout flag, so that software collects a short tail of data below the trigger level. Writes to the FIFO control register are decoded here. They set the enable, the receive reset and the trigger-level select. A change of the enable bit also emits a one-cycle flush pulse for the transmit side.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset, level is 0, buffering is off (fifo_on=0), data_ready, overrun, break_flag, timeout, rx_trig and tx_flush are 0, and rd_data is 0x00.
- R2: A control write sets the buffer enable from bit 0 and the trigger from bits 7:6 (00=1, 01=4, 10=8, 11=14 bytes). rx_trig is data_ready AND (buffering off OR level >= trigger).
- R3: With buffering on, bytes are read out in arrival order. level counts stored bytes. A push and a read in the same cycle leave level unchanged.
- R4: With buffering on and 16 bytes stored, an incoming byte is dropped, the stored bytes are kept and overrun is set. A read in the same cycle makes room for the byte instead.
- R5: With buffering off, each byte (a break counts as 0x00) overwrites the holding register and sets data_ready. overrun is set if data_ready was already set and no read happens in that cycle. A read clears data_ready and break_flag.
- R6: A read of an empty buffer returns 0x00 on rd_data and leaves level at 0.
- R7: A break strobe stores a 0x00 byte and sets both break_flag and data_ready. A break wins over a character strobe in the same cycle.
- R8: A buffered read that leaves the buffer empty clears data_ready and break_flag. Every buffered read clears timeout.
- R9: The timer loads four character times on every buffered push, and on every read that leaves data behind. timeout is set on the fourth char_tick after the last load if data is still stored. An emptying read stops the timer.
- R10: A line-status read (lsr_rd) clears overrun and break_flag. A new overrun or break in the same cycle takes precedence.
- R11: A control write with bit 1 set empties the buffer, clears data_ready, break_flag and timeout, and stops the timer. overrun is kept. Pushes and reads in that cycle are ignored.
- R12: A control write with bit 2 set, or with a bit 0 that differs from fifo_on, pulses tx_flush for one cycle after the write. An enable change also forces the R11 receive reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received-character strobe |
| rx_data | input | DW (8) | Received character |
| rx_break | input | 1 | Received-break strobe |
| rd_en | input | 1 | Receive-buffer read strobe |
| rd_data | output | DW (8) | Byte that a read in this cycle returns |
| lsr_rd | input | 1 | Line-status read strobe |
| cfg_we | input | 1 | FIFO control write strobe |
| cfg_wdata | input | 8 | FIFO control write value |
| char_tick | input | 1 | One pulse per character time |
| fifo_on | output | 1 | Buffering enabled |
| level | output | CW (5) | Number of stored bytes |
| rx_trig | output | 1 | Received-data condition met |
| data_ready | output | 1 | Data-ready flag |
| overrun | output | 1 | Overrun flag |
| break_flag | output | 1 | Break flag |
| timeout | output | 1 | Character-timeout flag |
| tx_flush | output | 1 | One-cycle transmit reset pulse |

## Verification
Every flag, level, fifo_on and tx_flush is a register, so each result appears one clock after the strobe that causes it. rd_data is a combinational view of the head of the buffer, and it is valid in the same cycle as the read strobe that consumes it. The bench drives each strobe for exactly one cycle. It samples one time unit after the rising edge that captures the strobe, and it checks rd_data just before issuing the read. For the timer, tick pulses are counted from the edge that loaded it, so timeout is checked after the third tick (still clear) and after the fourth tick (set).

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } trig_sel_e;

  function automatic int unsigned trig_bytes(input trig_sel_e sel);
    case (sel)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
  import rxb_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic          fifo_on,
  output logic [CW-1:0] trig_lvl,
  output logic          rx_clr,
  output logic          tx_flush
);
  localparam int B_EN  = 0;
  localparam int B_RXR = 1;
  localparam int B_TXR = 2;
  localparam int B_TRL = 6;

  logic      en_q, en_d;
  trig_sel_e trig_q, trig_d;
  logic      flush_q, flush_d;
  logic      en_change;
  logic      unused_bits;

  assign unused_bits = ^cfg_wdata[5:3];

  always_comb begin
    en_change = cfg_we & (cfg_wdata[B_EN] ^ en_q);
    rx_clr    = cfg_we & (cfg_wdata[B_RXR] | (cfg_wdata[B_EN] ^ en_q));
    flush_d   = cfg_we & (cfg_wdata[B_TXR] | en_change);
    en_d      = en_q;
    trig_d    = trig_q;
    if (cfg_we) begin
      en_d   = cfg_wdata[B_EN];
      trig_d = trig_sel_e'(cfg_wdata[B_TRL+1:B_TRL]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      trig_q  <= TRIG_1;
      flush_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      trig_q  <= trig_d;
      flush_q <= flush_d;
    end
  end

  assign fifo_on  = en_q;
  assign trig_lvl = CW'(trig_bytes(trig_q));
  assign tx_flush = flush_q;

  // R12: an enable change always produces a flush pulse
  a_r12_flush_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_wdata[B_EN] != en_q)) |=> tx_flush);

endmodule

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_f,
  input  logic          push_h,
  input  logic          pop,
  input  logic          fifo_on,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] hold_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_f) wr_d = nxt(wr_q);
      if (pop)    rd_d = nxt(rd_q);
      cnt_d = cnt_q + CW'(push_f) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (push_h) hold_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (push_f && !clr) mem[wr_q] <= wdata;
  end

  assign count   = cnt_q;
  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign rd_data = fifo_on ? (empty ? '0 : mem[rd_q]) : hold_q;

  // R3: storage never holds more than its depth
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R3: a simultaneous push and pop leaves the count unchanged
  a_r3_push_pop_same: assert property (@(posedge clk) disable iff (!rst_n)
    (push_f && pop && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/rxb_timer.sv
module rxb_timer #(
  parameter int TICKS = 4,
  localparam int TW   = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic stop,
  input  logic tick,
  output logic expire
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          armed;

  assign armed  = (cnt_q != '0);
  assign expire = tick && (cnt_q == TW'(1)) && !load && !stop;

  always_comb begin
    cnt_d = cnt_q;
    if (stop)              cnt_d = '0;
    else if (load)         cnt_d = TW'(TICKS);
    else if (tick && armed) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: a load always restarts a full window
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !stop) |=> (cnt_q == TW'(TICKS)));

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import rxb_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter int TMO_CHARS = 4,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_break,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          lsr_rd,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  input  logic          char_tick,
  output logic          fifo_on,
  output logic [CW-1:0] level,
  output logic          rx_trig,
  output logic          data_ready,
  output logic          overrun,
  output logic          break_flag,
  output logic          timeout,
  output logic          tx_flush
);
  logic          clr;
  logic [CW-1:0] trig_lvl;
  logic          full, empty;
  logic          byte_in;
  logic [DW-1:0] byte_val;
  logic          rd_f, pop, room, push_f, push_h, ovr_set, left_empty;
  logic          t_load, t_stop, t_expire;
  logic          dr_q, dr_d, brk_q, brk_d, ovr_q, ovr_d, tmo_q, tmo_d;

  rxb_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .fifo_on(fifo_on), .trig_lvl(trig_lvl), .rx_clr(clr), .tx_flush(tx_flush)
  );

  rxb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push_f(push_f), .push_h(push_h),
    .pop(pop), .fifo_on(fifo_on), .wdata(byte_val), .rd_data(rd_data),
    .count(level), .full(full), .empty(empty)
  );

  rxb_timer #(.TICKS(TMO_CHARS)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .stop(t_stop),
    .tick(char_tick), .expire(t_expire)
  );

  always_comb begin
    byte_in    = rx_valid | rx_break;
    byte_val   = rx_break ? '0 : rx_data;
    rd_f       = rd_en & fifo_on & !clr;
    pop        = rd_f & !empty;
    room       = !full | pop;
    push_f     = byte_in & fifo_on & !clr & room;
    push_h     = byte_in & !fifo_on & !clr;
    ovr_set    = byte_in & !clr & (fifo_on ? !room : (dr_q & !rd_en));
    left_empty = pop & (level == CW'(1)) & !push_f;
    t_stop     = clr | left_empty;
    t_load     = push_f | (pop & !left_empty);
  end

  always_comb begin
    dr_d  = dr_q;
    brk_d = brk_q;
    tmo_d = tmo_q;
    ovr_d = ovr_q;
    if (ovr_set)     ovr_d = 1'b1;
    else if (lsr_rd) ovr_d = 1'b0;
    if (clr) begin
      dr_d  = 1'b0;
      brk_d = 1'b0;
      tmo_d = 1'b0;
    end else begin
      if (byte_in)                         dr_d = 1'b1;
      else if (fifo_on ? left_empty : rd_en) dr_d = 1'b0;
      if (rx_break)                        brk_d = 1'b1;
      else if ((fifo_on ? left_empty : rd_en) || lsr_rd) brk_d = 1'b0;
      if (t_expire && !empty)              tmo_d = 1'b1;
      else if (rd_f)                       tmo_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q  <= 1'b0;
      brk_q <= 1'b0;
      ovr_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      dr_q  <= dr_d;
      brk_q <= brk_d;
      ovr_q <= ovr_d;
      tmo_q <= tmo_d;
    end
  end

  assign data_ready = dr_q;
  assign break_flag = brk_q;
  assign overrun    = ovr_q;
  assign timeout    = tmo_q;
  assign rx_trig    = dr_q & (!fifo_on | (level >= trig_lvl));

  // R4: a byte arriving at a full buffer with no read is dropped and flagged
  a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_on && level == CW'(DEPTH) && byte_in && !rd_en && !cfg_we)
    |=> (overrun && level == CW'(DEPTH)));

  // R9: the timeout flag is only ever held while data is stored
  a_r9_tmo_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (level != '0));

  // R11: a receive reset leaves an empty, quiet buffer
  a_r11_rx_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[1]) |=> (level == '0 && !data_ready && !timeout && !break_flag));

  // R8: a read of the last byte clears data-ready and break
  a_r8_last_read: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_on && rd_en && level == CW'(1) && !byte_in && !cfg_we)
    |=> (!data_ready && !break_flag));

endmodule

// File: tb/sim_uart_rx_buffer.sv
module sim_uart_rx_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_break = 1'b0, rd_en = 1'b0, lsr_rd = 1'b0;
  logic       cfg_we = 1'b0, char_tick = 1'b0;
  logic [7:0] rx_data = 8'h00, cfg_wdata = 8'h00;
  logic [7:0] rd_data;
  logic [4:0] level;
  logic       fifo_on, rx_trig, data_ready, overrun, break_flag, timeout, tx_flush;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_buffer u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .rd_en(rd_en), .rd_data(rd_data), .lsr_rd(lsr_rd),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .char_tick(char_tick),
    .fifo_on(fifo_on), .level(level), .rx_trig(rx_trig),
    .data_ready(data_ready), .overrun(overrun), .break_flag(break_flag),
    .timeout(timeout), .tx_flush(tx_flush)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    rx_valid = 0; rx_break = 0; rd_en = 0; lsr_rd = 0; cfg_we = 0; char_tick = 0;
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1; rx_data = b; step();
  endtask

  task automatic brk();
    rx_break = 1; step();
  endtask

  task automatic rd(input string tag, input logic [7:0] exp);
    chk(tag, rd_data, exp);
    rd_en = 1; step();
  endtask

  task automatic fcr(input logic [7:0] v);
    cfg_we = 1; cfg_wdata = v; step();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      char_tick = 1; step();
    end
  endtask

  task automatic t_reset();
    chk("R1 level", level, 0);
    chk("R1 fifo_on", fifo_on, 0);
    chk("R1 flags", {data_ready, overrun, break_flag, timeout, rx_trig, tx_flush}, 0);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_holding();
    push(8'h41);
    chk("R5 dr", data_ready, 1);
    chk("R5 hold", rd_data, 8'h41);
    chk("R5 no ovr", overrun, 0);
    chk("R2 trig when off", rx_trig, 1);
    push(8'h42);
    chk("R5 ovr", overrun, 1);
    chk("R5 overwrite", rd_data, 8'h42);
    rd("R5 read", 8'h42);
    chk("R5 dr clr", data_ready, 0);
    lsr_rd = 1; step();
    chk("R10 ovr clr", overrun, 0);
  endtask

  task automatic t_enable();
    fcr(8'h01);
    chk("R12 fifo_on", fifo_on, 1);
    chk("R12 flush", tx_flush, 1);
    step();
    chk("R12 flush one cycle", tx_flush, 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
    chk("R3 level5", level, 5);
    rd("R3 first", 8'h10);
    rd("R3 second", 8'h11);
    chk("R3 level3", level, 3);
    rx_valid = 1; rx_data = 8'h15; rd_en = 1;
    chk("R3 head", rd_data, 8'h12);
    step();
    chk("R3 push+pop level", level, 3);
    rd("R3 o3", 8'h13);
    rd("R3 o4", 8'h14);
    rd("R3 o5", 8'h15);
    chk("R8 dr empty", data_ready, 0);
  endtask

  task automatic t_trig();
    fcr(8'h41);
    chk("R2 no reset", fifo_on, 1);
    for (int i = 0; i < 3; i++) push(8'h01);
    chk("R2 below 4", rx_trig, 0);
    push(8'h01);
    chk("R2 at 4", rx_trig, 1);
    fcr(8'h81);
    chk("R2 below 8", rx_trig, 0);
    for (int i = 0; i < 4; i++) push(8'h01);
    chk("R2 at 8", rx_trig, 1);
    fcr(8'hC1);
    chk("R2 below 14", rx_trig, 0);
    for (int i = 0; i < 6; i++) push(8'h01);
    chk("R2 at 14", rx_trig, 1);
    fcr(8'h03);
    chk("R11 level", level, 0);
    chk("R11 dr", data_ready, 0);
    push(8'h01);
    chk("R2 at 1", rx_trig, 1);
    fcr(8'h03);
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) push(8'h20 + 8'(i));
    chk("R4 full", level, 16);
    chk("R4 no ovr yet", overrun, 0);
    push(8'hEE);
    chk("R4 ovr", overrun, 1);
    chk("R4 level kept", level, 16);
    for (int i = 0; i < 16; i++) rd("R4 kept", 8'h20 + 8'(i));
    chk("R8 dr", data_ready, 0);
    chk("R6 empty data", rd_data, 0);
    rd("R6 empty read", 8'h00);
    chk("R6 level", level, 0);
  endtask

  task automatic t_break();
    push(8'h55);
    brk();
    chk("R7 level", level, 2);
    chk("R7 brk", break_flag, 1);
    chk("R7 dr", data_ready, 1);
    rd("R7 first", 8'h55);
    chk("R8 brk kept", break_flag, 1);
    rd("R7 zero", 8'h00);
    chk("R8 brk clr", break_flag, 0);
    chk("R8 dr clr", data_ready, 0);
  endtask

  task automatic t_timeout();
    push(8'h33);
    ticks(3);
    chk("R9 not yet", timeout, 0);
    ticks(1);
    chk("R9 expired", timeout, 1);
    rd("R9 data", 8'h33);
    chk("R8 tmo clr", timeout, 0);
    push(8'h34); push(8'h35);
    ticks(3);
    push(8'h36);
    ticks(3);
    chk("R9 reload push", timeout, 0);
    ticks(1);
    chk("R9 after reload", timeout, 1);
    rd("R9 read", 8'h34);
    chk("R8 tmo read", timeout, 0);
    ticks(3);
    chk("R9 reload read", timeout, 0);
    ticks(1);
    chk("R9 expire 2", timeout, 1);
  endtask

  task automatic t_clear();
    for (int i = 0; i < 15; i++) push(8'h00);
    chk("R4 full again", level, 16);
    push(8'h77);
    chk("R4 ovr again", overrun, 1);
    fcr(8'h03);
    chk("R11 empty", level, 0);
    chk("R11 tmo", timeout, 0);
    chk("R11 ovr kept", overrun, 1);
    ticks(5);
    chk("R11 timer stopped", timeout, 0);
    brk(); lsr_rd = 1; step();
    chk("R10 clr brk", break_flag, 0);
    chk("R10 clr ovr", overrun, 0);
    fcr(8'h00);
    chk("R12 off", fifo_on, 0);
    chk("R12 flush off", tx_flush, 1);
    chk("R12 forced reset", level, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_holding();
    t_enable();
    t_order();
    t_trig();
    t_full();
    t_break();
    t_timeout();
    t_clear();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule